// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block turns queued bytes into asynchronous serial characters on one output line. Software pushes bytes into a small internal queue through a write strobe. Whenever the block is enabled and the queue holds data, the transmitter takes the oldest byte and sends it as a frame. A frame is a low start bit, then the data field least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts sixteen pulses of an externally supplied baud tick.

The frame format can be changed at run time. The data field can be five to eight bits long, parity can be off, even or odd, and one or two stop bits can be selected. The block takes a copy of the format at the moment it fetches each character, so a format change never alters a frame already on the line.

Two enable inputs must both be high for a new character to be fetched. If either one drops while a frame is on the line, that frame still completes. The line then stays idle, and any remaining bytes stay in the queue until the block is enabled again. A busy output covers the whole span from the first start bit to the last stop bit of a run of characters.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is high, busy is low and the queue-full flag is low; whenever busy is low the line is high.
- R2: Each frame opens with one low start bit and then sends the data field least significant bit first. Every bit holds for 16 baud ticks, and the line changes only after a baud tick or a character fetch.
- R3: The 2-bit length select picks the data field length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of the byte are sent.
- R4: With parity enabled, one parity bit follows the last data bit. The parity is taken over the sent data bits only. With the odd select low, the bit makes the count of ones even; with it high, the count is odd.
- R5: Each frame ends with high stop bits: one stop bit when the stop select is low, two when it is high.
- R6: The queue holds 4 bytes and sends them in write order. The full flag is high when 4 bytes wait. A write while full is dropped.
- R7: A character is fetched only when both enables are high and the queue is not empty. Otherwise no frame starts and the line stays high.
- R8: If an enable falls while a frame is on the line, that frame finishes unchanged. No further frame starts until both enables are high again, and the queued bytes are then sent.
- R9: The format inputs are sampled when a character is fetched. Changes during a frame do not affect that frame.
- R10: Busy rises with the start bit and stays high, with no gap between characters sent back to back, until the last stop bit of the final character ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| en | input | 1 | Module enable |
| tx_en | input | 1 | Transmit path enable |
| cfg_len | input | 2 | Data length select (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when high, even when low |
| cfg_stop2 | input | 1 | Two stop bits when high |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds 4 bytes |
| busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial line, idles high |

## Verification
The assertions assume that baud_tick is a single-cycle pulse synchronous to clk. They also assume that the enables and format inputs change only between clock edges, and that reset stays low long enough to flush the internal synchronizer. The stimulus drives every input on the falling clock edge and toggles baud_tick there every other cycle, so each bit spans 32 clocks. Format inputs are deliberately scrambled right after each start bit appears, which stays within these assumptions while testing the sampling rule. The sweep runs all 16 format combinations, with four data patterns each and both stop-bit settings. It also covers queue overflow, back-to-back sends and a mid-frame disable.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_PAR   = 3'd3,
    TX_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } tx_cfg_t;

  localparam int unsigned MIN_BITS = 5;

endpackage

// File: rtl/txf_rst_sync.sv
module txf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/txf_fifo.sv
module txf_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [DW-1:0] mem_q [DEPTH];
  logic          wr_ok, rd_ok;

  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign empty = (wp_q == rp_q);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (wr_ok) wp_d = wp_q + PW'(1);
    if (rd_ok) rp_d = rp_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem_q[rp_q[AW-1:0]];

endmodule

// File: rtl/txf_bit_timer.sv
module txf_bit_timer #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic bit_done
);

  localparam int unsigned CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] sub_q, sub_d;
  logic          adv;

  assign adv      = run && tick;
  assign bit_done = adv && (sub_q == LAST);

  always_comb begin
    sub_d = sub_q;
    if (restart)  sub_d = '0;
    else if (adv) sub_d = (sub_q == LAST) ? '0 : sub_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end

endmodule

// File: rtl/txf_serializer.sv
module txf_serializer
  import uart_tx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  input  tx_cfg_t       cfg_in,
  input  logic          bit_done,
  output logic          load,
  output logic          busy,
  output logic          txd,
  output tx_cfg_t       cfg_q
);

  localparam int unsigned CNTW = $clog2(DW);

  tx_state_e     state_q, state_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic          stop_q, stop_d;
  logic          par_q, par_d;
  tx_cfg_t       cfg_d;
  logic [CNTW-1:0] last_idx;
  logic          can_go;

  assign can_go   = enable && !fifo_empty;
  assign last_idx = CNTW'(MIN_BITS - 1) + CNTW'(cfg_q.len_sel);

  // next-state process
  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    stop_d  = stop_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    load    = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (can_go) load = 1'b1;
      end
      TX_START: begin
        if (bit_done) begin
          state_d = TX_DATA;
          cnt_d   = '0;
        end
      end
      TX_DATA: begin
        if (bit_done) begin
          sh_d  = sh_q >> 1;
          par_d = par_q ^ sh_q[0];
          if (cnt_q == last_idx) begin
            state_d = cfg_q.par_en ? TX_PAR : TX_STOP;
            stop_d  = 1'b0;
          end else begin
            cnt_d = cnt_q + CNTW'(1);
          end
        end
      end
      TX_PAR: begin
        if (bit_done) begin
          state_d = TX_STOP;
          stop_d  = 1'b0;
        end
      end
      TX_STOP: begin
        if (bit_done) begin
          if (cfg_q.stop2 && !stop_q) stop_d = 1'b1;
          else if (can_go)            load   = 1'b1;
          else                        state_d = TX_IDLE;
        end
      end
      default: state_d = TX_IDLE;
    endcase
    if (load) begin
      state_d = TX_START;
      sh_d    = fifo_data;
      cfg_d   = cfg_in;
      par_d   = cfg_in.par_odd;
      cnt_d   = '0;
      stop_d  = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      stop_q  <= stop_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh_q[0];
      TX_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign busy = (state_q != TX_IDLE);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned FIFO_DEPTH    = 4,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              en,
  input  logic              tx_en,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_full,
  output logic              busy,
  output logic              txd
);

  logic              rst_n_s;
  logic              fifo_empty;
  logic [DATA_W-1:0] fifo_q;
  logic              load;
  logic              bit_done;
  logic              path_on;
  tx_cfg_t           cfg_now;
  tx_cfg_t           cfg_lat;

  assign path_on = en && tx_en;
  assign cfg_now = '{len_sel: cfg_len, par_en: cfg_par_en,
                     par_odd: cfg_par_odd, stop2: cfg_stop2};

  txf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  txf_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .rd_en   (load),
    .rd_data (fifo_q),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  txf_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (busy),
    .restart  (load && !busy),
    .tick     (baud_tick),
    .bit_done (bit_done)
  );

  txf_serializer #(.DW(DATA_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .enable     (path_on),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_q),
    .cfg_in     (cfg_now),
    .bit_done   (bit_done),
    .load       (load),
    .busy       (busy),
    .txd        (txd),
    .cfg_q      (cfg_lat)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
  import uart_tx_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    baud_tick,
  input logic    en,
  input logic    tx_en,
  input logic    fifo_full,
  input logic    busy,
  input logic    txd,
  input logic    load,
  input tx_cfg_t cfg_lat
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd) else $error("line low while idle"); // R1

  AST_START_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd) else $error("frame did not open low"); // R2

  AST_TXD_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($past(baud_tick) || $past(load))) else $error("line moved between ticks"); // R2

  AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (txd && $past(txd))) else $error("frame ended without stop level"); // R5

  AST_FULL_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !(en && tx_en)) |=> fifo_full) else $error("queue drained while disabled"); // R6

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(en && tx_en)) |=> !busy) else $error("frame started while disabled"); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_lat)) else $error("format changed mid-frame"); // R9

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .en        (en),
  .tx_en     (tx_en),
  .fifo_full (fifo_full),
  .busy      (busy),
  .txd       (txd),
  .load      (load),
  .cfg_lat   (cfg_lat)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       en, tx_en;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_odd, cfg_stop2;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       fifo_full, busy, txd;

  int n_chk = 0;
  int n_bad = 0;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .en(en), .tx_en(tx_en),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .wr_valid(wr_valid), .wr_data(wr_data),
    .fifo_full(fifo_full), .busy(busy), .txd(txd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  task automatic set_cfg(input int nb, input bit pe, input bit po, input bit s2);
    cfg_len     = 2'(nb - 5);
    cfg_par_en  = pe;
    cfg_par_odd = po;
    cfg_stop2   = s2;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Receive one frame from the line and compare against the expected format.
  task automatic rx_frame(input logic [7:0] d, input int nb, input bit pe, input bit po,
                          input bit s2, input bit gap_chk, input bit drop_en, input bit last);
    int   t = 0;
    bit   gap = 1'b0;
    logic exp_par;
    while (txd !== 1'b0 && t <= 5000) begin
      @(negedge clk);
      if (gap_chk && !busy) gap = 1'b1;
      t++;
    end
    chk(t <= 5000, "R7 frame start seen", t, 0);
    if (gap_chk) chk(!gap, "R10 busy gap between frames", int'(gap), 0);
    // scramble format mid-frame (R9)
    cfg_len     = ~cfg_len;
    cfg_par_en  = ~cfg_par_en;
    cfg_par_odd = ~cfg_par_odd;
    cfg_stop2   = ~cfg_stop2;
    if (drop_en) en = 1'b0;
    repeat (16) @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
    chk(busy == 1'b1, "R10 busy during start", int'(busy), 1);
    for (int i = 0; i < nb; i++) begin
      repeat (32) @(negedge clk);
      chk(txd == d[i], "R2 R3 R9 data bit", int'(txd), int'(d[i]));
    end
    if (pe) begin
      exp_par = po;
      for (int i = 0; i < nb; i++) exp_par = exp_par ^ d[i];
      repeat (32) @(negedge clk);
      chk(txd == exp_par, "R4 parity bit", int'(txd), int'(exp_par));
    end
    repeat (32) @(negedge clk);
    chk(txd == 1'b1, "R5 first stop bit", int'(txd), 1);
    chk(busy == 1'b1, "R10 busy in stop", int'(busy), 1);
    if (s2) begin
      repeat (32) @(negedge clk);
      chk(txd == 1'b1 && busy == 1'b1, "R5 second stop bit", int'({busy, txd}), 3);
    end
    set_cfg(nb, pe, po, s2);
    if (last) begin
      repeat (18) @(negedge clk);
      chk(busy == 1'b0, "R5 R10 busy drops after stop", int'(busy), 0);
      chk(txd == 1'b1, "R1 idle high after frame", int'(txd), 1);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    en       = 1'b1;
    tx_en    = 1'b1;
    wr_valid = 1'b0;
    wr_data  = '0;
    set_cfg(8, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(fifo_full == 1'b0, "R1 full after reset", int'(fifo_full), 0);

    // R6 / R7: fill queue with transmit path off, overflow dropped
    tx_en = 1'b0;
    for (int k = 1; k <= 5; k++) wr(8'(k * 17));
    repeat (200) @(negedge clk);
    chk(fifo_full == 1'b1, "R6 full after four writes", int'(fifo_full), 1);
    chk(busy == 1'b0 && txd == 1'b1, "R7 no frame while path off", int'({busy, txd}), 1);
    tx_en = 1'b1;
    for (int k = 1; k <= 4; k++)
      rx_frame(8'(k * 17), 8, 1'b0, 1'b0, 1'b0, k > 1, 1'b0, k == 4);
    repeat (400) @(negedge clk);
    chk(busy == 1'b0, "R6 dropped fifth write not sent", int'(busy), 0);
    chk(fifo_full == 1'b0, "R6 full clears when drained", int'(fifo_full), 0);

    // Sweep all formats: R2 R3 R4 R5 R9
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = 8'(c * 29 + k * 71 + 53);
        set_cfg(5 + (c % 4), c[2], c[3], k[0]);
        wr(d);
        rx_frame(d, 5 + (c % 4), c[2], c[3], k[0], 1'b0, 1'b0, 1'b1);
      end
    end

    // R10 back to back
    set_cfg(6, 1'b1, 1'b1, 1'b0);
    wr(8'h2B);
    wr(8'h14);
    rx_frame(8'h2B, 6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_frame(8'h14, 6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);

    // R8 disable mid-frame
    set_cfg(7, 1'b1, 1'b0, 1'b1);
    wr(8'h6D);
    wr(8'h33);
    wr(8'h4E);
    rx_frame(8'h6D, 7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    begin
      bit moved = 1'b0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (busy || !txd) moved = 1'b1;
      end
      chk(!moved, "R8 stays idle after disable", int'(moved), 0);
    end
    en = 1'b1;
    rx_frame(8'h33, 7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_frame(8'h4E, 7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);

    summary();
    $finish;
  end

endmodule